// File: doc/BRIEF.md
# Atomic Update Reservation Monitor

This block watches over one address reservation for a single hardware thread, so that software can build an atomic read-modify-write on shared memory. The sequence is a locked load, a change made in registers, a conditional store, and a test of the status that store returns. The locked load records the quadword that was read and arms a valid flag. The conditional store may reach memory only when that flag is still set and its address falls in the same quadword.

The flag drops on an interrupt, on an exception, or when another agent is seen writing the reserved quadword. Each conditional store produces a status value of one (committed) or zero (refused) for its destination register. Software tests that value and repeats the sequence on zero. The block gives no ordering guarantee beyond its own reservation.

Locked-load and snoop addresses arrive as quadword indices, meaning byte address bits from `GRAN_LSB` upward. The conditional store carries a full byte address, and its low `GRAN_LSB` bits are ignored when it is compared. All outputs are registered. A conditional store presented at one rising edge shows its memory write and its status write-back after that edge, both in the same cycle.

Top module: `resv_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after it, there is no reservation and mem_we, wb_en, wb_value, mem_addr, mem_wdata and wb_reg are all zero.
- R2: A conditional store whose address bits [AW-1:3] equal the quadword index of an earlier locked load succeeds, with no interrupt, exception, matching snoop or other conditional store in between. Bits [2:0] of its address have no effect. One cycle after the request, mem_we=1 and wb_en=1.
- R3: A conditional store to a different quadword than the one reserved fails: mem_we=0, wb_en=1, wb_value=0.
- R4: A conditional store with no reservation held fails.
- R5: An interrupt in any cycle after the locked load, up to and including the cycle of the conditional store, makes that store fail.
- R6: An exception in any cycle after the locked load, up to and including the cycle of the conditional store, makes that store fail.
- R7: A snoop whose quadword index equals the reserved one clears the reservation. A snoop to any other quadword leaves it intact.
- R8: Every conditional store clears the reservation, whether it succeeds or fails, so a second store without a new locked load fails.
- R9: A new locked load replaces any earlier reservation. Only the latest quadword can then succeed.
- R10: When a matching snoop and a conditional store arrive in the same cycle, the snoop wins and the store fails.
- R11: A conditional store drives wb_en=1 with wb_reg set to its destination index. wb_value is 1 on success and 0 on failure, with bits [DW-1:1] zero. mem_we rises only together with a status of 1. mem_addr and mem_wdata carry the store's address and data. Outside conditional-store cycles all of these outputs are zero.
- R12: A conditional store in the same cycle as a locked load is judged against the old reservation, and the new one takes effect afterwards. A locked load in the same cycle as an interrupt, an exception or a snoop to its own quadword arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Locked-load request |
| ll_qw | input | AW-GRAN_LSB | Quadword index read by the locked load |
| sc_req | input | 1 | Conditional-store request |
| sc_addr | input | AW | Byte address of the conditional store |
| sc_wdata | input | DW | Data to store |
| sc_rdst | input | RW | Register that receives the status |
| irq_evt | input | 1 | Interrupt taken this cycle |
| exc_evt | input | 1 | Exception taken this cycle |
| snoop_vld | input | 1 | Write by another agent seen this cycle |
| snoop_qw | input | AW-GRAN_LSB | Quadword index of that write |
| mem_we | output | 1 | Memory write enable for a committed store |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| wb_en | output | 1 | Status write-back enable |
| wb_reg | output | RW | Status destination register |
| wb_value | output | DW | Status: 1 success, 0 failure |

## Verification
The functions that can meet in one cycle are the judgement of a conditional store and the clearing of the reservation by a snoop. A locked load can also meet a store or a clearing event. Directed cases put a snoop to the reserved quadword on the very edge of the store, and a locked load on the edge of a store or an interrupt. A long stretch of random traffic over a few quadwords then lets such collisions happen often. Every cycle is judged against a behavioural model that applies the snoop-wins rule and the old-reservation-first rule.

// File: rtl/resv_pkg.sv
package resv_pkg;
    localparam int unsigned RESV_AW       = 64;
    localparam int unsigned RESV_DW       = 64;
    localparam int unsigned RESV_RW       = 5;
    localparam int unsigned RESV_GRAN_LSB = 3;

    localparam logic STATUS_OK   = 1'b1;
    localparam logic STATUS_FAIL = 1'b0;
endpackage

// File: rtl/resv_granule_cmp.sv
module resv_granule_cmp #(
    parameter int unsigned TAG_W = 61
) (
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    input  logic             qual,
    output logic             hit
);
    always_comb begin
        hit = qual && (tag_a == tag_b);
    end
endmodule

// File: rtl/resv_commit_unit.sv
module resv_commit_unit (
    input  logic sc_req,
    input  logic resv_vld,
    input  logic sc_hit,
    input  logic snoop_kill,
    input  logic irq_evt,
    input  logic exc_evt,
    output logic commit,
    output logic drop_resv
);
    always_comb begin
        // snoop, interrupt and exception override a matching store
        commit    = sc_req && resv_vld && sc_hit && !snoop_kill && !irq_evt && !exc_evt;
        drop_resv = sc_req || snoop_kill || irq_evt || exc_evt;
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int unsigned AW       = resv_pkg::RESV_AW,
    parameter int unsigned DW       = resv_pkg::RESV_DW,
    parameter int unsigned RW       = resv_pkg::RESV_RW,
    parameter int unsigned GRAN_LSB = resv_pkg::RESV_GRAN_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ll_req,
    input  logic [AW-GRAN_LSB-1:0] ll_qw,
    input  logic                 sc_req,
    input  logic [AW-1:0]        sc_addr,
    input  logic [DW-1:0]        sc_wdata,
    input  logic [RW-1:0]        sc_rdst,
    input  logic                 irq_evt,
    input  logic                 exc_evt,
    input  logic                 snoop_vld,
    input  logic [AW-GRAN_LSB-1:0] snoop_qw,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic                 wb_en,
    output logic [RW-1:0]        wb_reg,
    output logic [DW-1:0]        wb_value
);
    localparam int unsigned TAG_W = AW - GRAN_LSB;

    typedef struct packed {
        logic             resv_vld;
        logic [TAG_W-1:0] resv_tag;
        logic             we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             wb;
        logic [RW-1:0]    rdst;
        logic             ok;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [TAG_W-1:0] sc_tag;
    logic sc_hit, snoop_hit_resv, snoop_hit_ll;
    logic commit, drop_resv;

    assign sc_tag = sc_addr[AW-1:GRAN_LSB];

    resv_granule_cmp #(.TAG_W(TAG_W)) u_sc_cmp (
        .tag_a(sc_tag), .tag_b(st_q.resv_tag), .qual(sc_req), .hit(sc_hit)
    );

    resv_granule_cmp #(.TAG_W(TAG_W)) u_snp_resv_cmp (
        .tag_a(snoop_qw), .tag_b(st_q.resv_tag), .qual(snoop_vld && st_q.resv_vld),
        .hit(snoop_hit_resv)
    );

    resv_granule_cmp #(.TAG_W(TAG_W)) u_snp_ll_cmp (
        .tag_a(snoop_qw), .tag_b(ll_qw), .qual(snoop_vld && ll_req), .hit(snoop_hit_ll)
    );

    resv_commit_unit u_commit (
        .sc_req    (sc_req),
        .resv_vld  (st_q.resv_vld),
        .sc_hit    (sc_hit),
        .snoop_kill(snoop_hit_resv),
        .irq_evt   (irq_evt),
        .exc_evt   (exc_evt),
        .commit    (commit),
        .drop_resv (drop_resv)
    );

    always_comb begin
        st_d = st_q;
        // store result: judged against the reservation held before this edge
        st_d.we    = commit;
        st_d.ok    = sc_req ? (commit ? resv_pkg::STATUS_OK : resv_pkg::STATUS_FAIL) : 1'b0;
        st_d.wb    = sc_req;
        st_d.addr  = sc_req ? sc_addr  : '0;
        st_d.wdata = sc_req ? sc_wdata : '0;
        st_d.rdst  = sc_req ? sc_rdst  : '0;
        // reservation update: a locked load overrides the old one
        if (ll_req) begin
            st_d.resv_tag = ll_qw;
            st_d.resv_vld = !(irq_evt || exc_evt || snoop_hit_ll);
        end else if (drop_resv) begin
            st_d.resv_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign wb_en     = st_q.wb;
    assign wb_reg    = st_q.rdst;
    assign wb_value  = {{(DW-1){1'b0}}, st_q.ok};

    AST_SC_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> wb_en); // R2
    AST_TAG_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && sc_addr[AW-1:GRAN_LSB] != st_q.resv_tag) |=> !mem_we); // R3
    AST_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !st_q.resv_vld) |=> !mem_we); // R4
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> (!st_q.resv_vld && !mem_we)); // R5
    AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_evt |=> (!st_q.resv_vld && !mem_we)); // R6
    AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_vld && st_q.resv_vld && snoop_qw == st_q.resv_tag && !ll_req) |=> !st_q.resv_vld); // R7
    AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !ll_req) |=> !st_q.resv_vld); // R8
    AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_req && !irq_evt && !exc_evt && !(snoop_vld && snoop_qw == ll_qw))
        |=> (st_q.resv_vld && st_q.resv_tag == $past(ll_qw))); // R9
    AST_SNOOP_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && snoop_vld && snoop_qw == sc_addr[AW-1:GRAN_LSB]) |=> !mem_we); // R10
    AST_WE_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wb_en && wb_value == DW'(1))); // R11
endmodule

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;
    localparam int AW = 64;
    localparam int DW = 64;
    localparam int RW = 5;
    localparam int GL = 3;
    localparam int TW = AW - GL;

    logic clk = 1'b0;
    logic rst_n;
    logic ll_req, sc_req, irq_evt, exc_evt, snoop_vld;
    logic [TW-1:0] ll_qw, snoop_qw;
    logic [AW-1:0] sc_addr;
    logic [DW-1:0] sc_wdata;
    logic [RW-1:0] sc_rdst;
    logic mem_we, wb_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, wb_value;
    logic [RW-1:0] wb_reg;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference
    bit m_vld = 0;
    logic [TW-1:0] m_tag = '0;
    bit e_we, e_wb, e_ok;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    logic [RW-1:0] e_reg;

    always #2.5 clk = ~clk;

    resv_monitor u0 (
        .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_qw(ll_qw),
        .sc_req(sc_req), .sc_addr(sc_addr), .sc_wdata(sc_wdata), .sc_rdst(sc_rdst),
        .irq_evt(irq_evt), .exc_evt(exc_evt), .snoop_vld(snoop_vld), .snoop_qw(snoop_qw),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value)
    );

    task automatic compare_all();
        checks++;
        if (mem_we !== e_we || wb_en !== e_wb || wb_value !== {{(DW-1){1'b0}}, e_ok} ||
            mem_addr !== e_addr || mem_wdata !== e_data || wb_reg !== e_reg) begin
            errors++;
            $display("FAIL %s t=%0t act we=%b wb=%b val=%h addr=%h data=%h reg=%0d exp we=%b wb=%b ok=%b addr=%h data=%h reg=%0d",
                     cur_req, $time, mem_we, wb_en, wb_value, mem_addr, mem_wdata, wb_reg,
                     e_we, e_wb, e_ok, e_addr, e_data, e_reg);
        end
    endtask

    task automatic step(input bit ll, input logic [TW-1:0] lq, input bit sc,
                        input logic [AW-1:0] sa, input logic [DW-1:0] sd, input logic [RW-1:0] sr,
                        input bit irq, input bit exc, input bit sv, input logic [TW-1:0] sq);
        bit kill, pass;
        ll_req = ll; ll_qw = lq; sc_req = sc; sc_addr = sa; sc_wdata = sd; sc_rdst = sr;
        irq_evt = irq; exc_evt = exc; snoop_vld = sv; snoop_qw = sq;
        kill = sv && m_vld && (sq == m_tag);
        pass = sc && m_vld && (sa[AW-1:GL] == m_tag) && !irq && !exc && !kill;
        e_we = pass; e_wb = sc; e_ok = pass;
        e_addr = sc ? sa : '0; e_data = sc ? sd : '0; e_reg = sc ? sr : '0;
        if (ll) begin
            m_tag = lq;
            m_vld = !(irq || exc || (sv && sq == lq));
        end else if (sc || irq || exc || kill) begin
            m_vld = 0;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(0, '0, 0, '0, '0, '0, 0, 0, 0, '0);
    endtask
    task automatic ll_op(input logic [TW-1:0] q);
        step(1, q, 0, '0, '0, '0, 0, 0, 0, '0);
    endtask
    task automatic sc_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [RW-1:0] r);
        step(0, '0, 1, a, d, r, 0, 0, 0, '0);
    endtask

    task automatic expect_status(input bit ok, input string req);
        checks++;
        if (wb_en !== 1'b1 || wb_value !== DW'(ok) || mem_we !== ok) begin
            errors++;
            $display("FAIL %s status act we=%b wb=%b val=%h exp we=%b wb=1 val=%0d",
                     req, mem_we, wb_en, wb_value, ok, ok);
        end
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0;
        ll_req = 0; ll_qw = '0; sc_req = 0; sc_addr = '0; sc_wdata = '0; sc_rdst = '0;
        irq_evt = 0; exc_evt = 0; snoop_vld = 0; snoop_qw = '0;
        e_we = 0; e_wb = 0; e_ok = 0; e_addr = '0; e_data = '0; e_reg = '0;
        repeat (3) @(negedge clk);
        cur_req = "R1"; compare_all();
        rst_n = 1;
        idle();
        cur_req = "R4"; sc_op(64'h40, 64'h11, 5'd1); expect_status(0, "R4");

        cur_req = "R2"; ll_op(61'h200); idle();
        sc_op(64'h1005, 64'hDEAD_BEEF, 5'd7); expect_status(1, "R2");
        cur_req = "R11";
        checks++;
        if (mem_addr !== 64'h1005 || mem_wdata !== 64'hDEAD_BEEF || wb_reg !== 5'd7) begin
            errors++;
            $display("FAIL R11 act addr=%h data=%h reg=%0d exp addr=1005 data=deadbeef reg=7",
                     mem_addr, mem_wdata, wb_reg);
        end
        idle();
        checks++;
        if (mem_we !== 0 || wb_en !== 0 || wb_value !== '0) begin
            errors++;
            $display("FAIL R11 idle act we=%b wb=%b val=%h exp 0 0 0", mem_we, wb_en, wb_value);
        end
        cur_req = "R8"; sc_op(64'h1000, 64'h2, 5'd3); expect_status(0, "R8");
        ll_op(61'h200); sc_op(64'h1008, 64'h2, 5'd3); expect_status(0, "R3");
        sc_op(64'h1000, 64'h2, 5'd3); expect_status(0, "R8");

        cur_req = "R5"; ll_op(61'h600); step(0, '0, 0, '0, '0, '0, 1, 0, 0, '0);
        sc_op(64'h3000, 64'h5, 5'd2); expect_status(0, "R5");
        ll_op(61'h600); step(0, '0, 1, 64'h3000, 64'h5, 5'd2, 1, 0, 0, '0); expect_status(0, "R5");
        cur_req = "R6"; ll_op(61'h600); step(0, '0, 0, '0, '0, '0, 0, 1, 0, '0);
        sc_op(64'h3000, 64'h5, 5'd2); expect_status(0, "R6");
        ll_op(61'h600); step(0, '0, 1, 64'h3000, 64'h5, 5'd2, 0, 1, 0, '0); expect_status(0, "R6");

        cur_req = "R7"; ll_op(61'h800); step(0, '0, 0, '0, '0, '0, 0, 0, 1, 61'h800);
        sc_op(64'h4007, 64'h6, 5'd4); expect_status(0, "R7");
        ll_op(61'h800); step(0, '0, 0, '0, '0, '0, 0, 0, 1, 61'h801);
        sc_op(64'h4000, 64'h6, 5'd4); expect_status(1, "R7");

        cur_req = "R10"; ll_op(61'hA00);
        step(0, '0, 1, 64'h5004, 64'h9, 5'd9, 0, 0, 1, 61'hA00); expect_status(0, "R10");

        cur_req = "R9"; ll_op(61'hC00); ll_op(61'hE00);
        sc_op(64'h6000, 64'h1, 5'd1); expect_status(0, "R9");
        ll_op(61'hC00); ll_op(61'hE00);
        sc_op(64'h7003, 64'h1, 5'd1); expect_status(1, "R9");

        cur_req = "R12"; ll_op(61'h1000);
        step(1, 61'h1200, 1, 64'h8000, 64'h3, 5'd5, 0, 0, 0, '0); expect_status(1, "R12");
        sc_op(64'h9000, 64'h4, 5'd6); expect_status(1, "R12");
        step(1, 61'h1200, 0, '0, '0, '0, 1, 0, 0, '0);
        sc_op(64'h9000, 64'h4, 5'd6); expect_status(0, "R12");
        step(1, 61'h1200, 0, '0, '0, '0, 0, 0, 1, 61'h1200);
        sc_op(64'h9000, 64'h4, 5'd6); expect_status(0, "R12");

        cur_req = "R2..R12 random";
        for (int i = 0; i < 3000; i++) begin
            logic [TW-1:0] lq, sq;
            logic [AW-1:0] sa;
            lq = TW'($urandom_range(0, 3));
            sq = TW'($urandom_range(0, 3));
            sa = {TW'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
            step($urandom_range(0, 3) == 0, lq, $urandom_range(0, 2) == 0, sa,
                 {$urandom, $urandom}, RW'($urandom_range(0, 31)),
                 $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
                 $urandom_range(0, 5) == 0, sq);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule